// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a configurable number of interrupt lines, up to 32, into one interrupt request for a processor. Each line is fixed at build time as edge-sensitive or level-sensitive. A latched event is held in a status bit and counts as pending only while its enable bit is set. The request to the processor is raised when any line is pending and both bits of the master control register are set.

Software reaches the block through a plain 32-bit register port with a byte address, a write strobe with data, and a read strobe. Read data appears one cycle after the read strobe. Through this port software can:

- inspect status and pending bits;
- load the enable bits whole, or set and clear them one by one through two separate masks;
- acknowledge latched events by mask;
- read the number of the lowest pending line;
- set the two master control bits.

Top module: `irqc_top`

## Requirements
- R1: Registers are 32-bit words selected by address bits [4:2]: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. The read strobe returns data on rd_data one clock later. Writes with address bits [1:0] not zero are ignored. Writes to status, pending and vector have no effect. Reads of acknowledge, set-enable and clear-enable return 0.
- R2: Writing a mask to set-enable sets the matching enable bits. Writing a mask to clear-enable clears them. Zero bits in the mask leave enable bits as they were.
- R3: Writing the enable word replaces all enable bits. Bits at or above NUM_IN read as 0. Writing 0 disables every line.
- R4: Writing a mask to acknowledge clears the matching status bits. Writing all ones clears every status bit whose line has no new event.
- R5: An edge-type line (EDGE_MASK bit = 1) sets its status bit on a 0-to-1 transition and holds it until acknowledged. A line that stays high does not set the bit again after the acknowledge.
- R6: A level-type line (EDGE_MASK bit = 0) sets its status bit in every cycle that it is high, so an acknowledge cannot clear the bit while the line stays high.
- R7: The pending word reads as status AND enable.
- R8: irq_out is high exactly when some pending bit is set and master bit 0 (run) and bit 1 (hardware enable) are both 1. It follows register changes in the same cycle, with no added delay.
- R9: The vector word reads the index of the lowest-numbered pending line, or 0xFFFFFFFF when no line is pending.
- R10: When a new event and an acknowledge of the same bit occur in the same cycle, the status bit ends up set.
- R11: After reset the status, enable and master registers are 0, irq_out is low and the vector reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Interrupt lines |
| addr | input | 5 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench drives three kinds of line activity, and each one separates behaviours that could otherwise be confused:

- **A single-cycle pulse on an edge line** shows that a short event is captured and held.
- **A line held high through an acknowledge** separates edge capture from level capture. A level line re-latches after the acknowledge; an edge line does not.
- **An edge that arrives in the same cycle as its acknowledge** shows that the new event wins.

With two lines pending at once, the vector read shows whether the lowest index is chosen. Switching each master bit off on its own shows that both bits gate the request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_PENDING = 3'd1,
        SEL_ENABLE  = 3'd2,
        SEL_ACK     = 3'd3,
        SEL_SETEN   = 3'd4,
        SEL_CLREN   = 3'd5,
        SEL_VECTOR  = 3'd6,
        SEL_MASTER  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic hw_en;
        logic run;
    } master_t;

    typedef struct packed {
        logic en_load;
        logic en_set;
        logic en_clr;
        logic ack;
        logic master;
    } wr_strobe_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[4:2]);
    endfunction

    function automatic wr_strobe_t decode_write(input logic we, input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s = '0;
        if (we && a[1:0] == 2'b00) begin
            unique case (decode_sel(a))
                SEL_ENABLE: s.en_load = 1'b1;
                SEL_SETEN:  s.en_set  = 1'b1;
                SEL_CLREN:  s.en_clr  = 1'b1;
                SEL_ACK:    s.ack     = 1'b1;
                SEL_MASTER: s.master  = 1'b1;
                default:    s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int          NUM_IN    = 8,
    parameter logic [31:0] EDGE_MASK = 32'h0000_00F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic [NUM_IN-1:0] ack_mask,
    output logic [NUM_IN-1:0] status,
    output logic [NUM_IN-1:0] event_hit
);

    for (genvar i = 0; i < NUM_IN; i++) begin : g_line
        if (EDGE_MASK[i]) begin : g_edge
            logic prev;
            always_ff @(posedge clk) begin
                if (rst) prev <= 1'b0;
                else     prev <= irq_in[i];
            end
            assign event_hit[i] = irq_in[i] & ~prev;
        end else begin : g_level
            assign event_hit[i] = irq_in[i];
            // R6: a high level line is latched at every edge
            p_level_relatch_r6: assert property (@(posedge clk) disable iff (rst)
                irq_in[i] |=> status[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~ack_mask) | event_hit;
    end

    // R5: without an acknowledge no latched bit drops
    p_hold_without_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_mask == '0) |=> ((status & $past(status)) == $past(status)));

    // R10: a fresh event survives a simultaneous acknowledge
    p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (ack_mask != '0) |=> ((status & $past(event_hit)) == $past(event_hit)));

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [NUM_IN-1:0] status,
    input  logic [DATA_W-1:0] vector,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_IN-1:0] enable,
    output master_t           master,
    output logic [NUM_IN-1:0] ack_mask
);

    wr_strobe_t        strobe;
    logic [NUM_IN-1:0] wmask;
    logic [DATA_W-1:0] status_w, enable_w, pend_w;
    logic [DATA_W-1:0] rd_mux;

    assign strobe   = decode_write(wr_en, addr);
    assign wmask    = wr_data[NUM_IN-1:0];
    assign ack_mask = strobe.ack ? wmask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
        end else if (strobe.en_load) begin
            enable <= wmask;
        end else if (strobe.en_set) begin
            enable <= enable | wmask;
        end else if (strobe.en_clr) begin
            enable <= enable & ~wmask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                master <= '0;
        else if (strobe.master) master <= master_t'(wr_data[1:0]);
    end

    always_comb begin
        status_w = '0;
        enable_w = '0;
        status_w[NUM_IN-1:0] = status;
        enable_w[NUM_IN-1:0] = enable;
        pend_w   = status_w & enable_w;
    end

    always_comb begin
        unique case (decode_sel(addr))
            SEL_STATUS:  rd_mux = status_w;
            SEL_PENDING: rd_mux = pend_w;
            SEL_ENABLE:  rd_mux = enable_w;
            SEL_VECTOR:  rd_mux = vector;
            SEL_MASTER:  rd_mux = {{(DATA_W-2){1'b0}}, master};
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    // R2: set-enable turns on every masked bit
    p_set_enable_r2: assert property (@(posedge clk) disable iff (rst)
        strobe.en_set |=> ((enable & $past(wmask)) == $past(wmask)));

    // R2: clear-enable turns off every masked bit
    p_clr_enable_r2: assert property (@(posedge clk) disable iff (rst)
        strobe.en_clr |=> ((enable & $past(wmask)) == '0));

    // R3: enable bits change only through the enable-related writes
    p_enable_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !(strobe.en_load || strobe.en_set || strobe.en_clr) |=> $stable(enable));

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic [NUM_IN-1:0] pending,
    output logic [DATA_W-1:0] vector,
    output logic              any
);

    always_comb begin
        vector = '1;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (pending[i]) vector = DATA_W'(i);
        end
    end

    assign any = |pending;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int          NUM_IN    = 8,
    parameter logic [31:0] EDGE_MASK = 32'h0000_00F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic [4:0]        addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              irq_out
);

    logic [NUM_IN-1:0] status, event_hit, enable, ack_mask, pending;
    logic [DATA_W-1:0] vector;
    logic              any_pend;
    master_t           master;

    irqc_capture #(.NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK)) u_capture (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ack_mask(ack_mask),
        .status(status), .event_hit(event_hit)
    );

    irqc_regfile #(.NUM_IN(NUM_IN)) u_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .status(status), .vector(vector), .rd_data(rd_data),
        .enable(enable), .master(master), .ack_mask(ack_mask)
    );

    assign pending = status & enable;

    irqc_prio #(.NUM_IN(NUM_IN)) u_prio (
        .pending(pending), .vector(vector), .any(any_pend)
    );

    assign irq_out = any_pend & master.run & master.hw_en;

    // R8: a request needs both master bits
    p_irq_needs_master_r8: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (master.run && master.hw_en));

    // R9: the vector names a pending line with no lower pending line
    p_vector_lowest_r9: assert property (@(posedge clk) disable iff (rst)
        any_pend |-> (pending[vector[4:0]] &&
                      ((pending & ((NUM_IN'(1) << vector[4:0]) - NUM_IN'(1))) == '0)));

    // R9: nothing pending gives an all-ones vector
    p_vector_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !any_pend |-> (vector == '1));

endmodule

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;

    localparam int NUM_IN = 8;
    localparam logic [31:0] EDGE_MASK = 32'h0000_00F0;
    localparam logic [4:0] A_STATUS = 5'h00, A_PEND = 5'h04, A_EN = 5'h08,
                           A_ACK = 5'h0C, A_SET = 5'h10, A_CLR = 5'h14,
                           A_VEC = 5'h18, A_MASTER = 5'h1C;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_IN-1:0] irq_in = '0;
    logic [4:0]        addr = '0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [31:0]       rd_data;
    logic              irq_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    irqc_top #(.NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK)) u_irqc_top (
        .clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_out(irq_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: compares each read result one cycle after its strobe
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en && !rst) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk("R1 unexpected read", rd_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, rd_data, e);
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 irq_out after reset", {31'b0, irq_out}, 32'h0);
        rd(A_STATUS, 32'h0, "R11 status reset");
        rd(A_EN, 32'h0, "R11 enable reset");
        rd(A_MASTER, 32'h0, "R11 master reset");
        rd(A_VEC, 32'hFFFF_FFFF, "R11 vector reset");

        wr(A_MASTER, 32'h3);
        rd(A_MASTER, 32'h3, "R1 master readback");

        // R5 single-cycle pulse on edge line 5
        @(negedge clk); irq_in = 8'h20;
        @(negedge clk); irq_in = 8'h00;
        rd(A_STATUS, 32'h20, "R5 edge pulse latched");
        rd(A_PEND, 32'h0, "R7 pending masked");
        chk("R8 irq low while disabled", {31'b0, irq_out}, 32'h0);

        wr(A_SET, 32'h24);
        rd(A_EN, 32'h24, "R2 set-enable");
        rd(A_PEND, 32'h20, "R7 pending = status & enable");
        chk("R8 irq high", {31'b0, irq_out}, 32'h1);
        rd(A_VEC, 32'd5, "R9 vector single");

        wr(A_MASTER, 32'h1);
        chk("R8 irq gated by hw enable bit", {31'b0, irq_out}, 32'h0);
        wr(A_MASTER, 32'h2);
        chk("R8 irq gated by run bit", {31'b0, irq_out}, 32'h0);
        wr(A_MASTER, 32'h3);
        chk("R8 irq restored", {31'b0, irq_out}, 32'h1);

        wr(A_CLR, 32'h04);
        rd(A_EN, 32'h20, "R2 clear-enable");

        // level line 2 held high
        @(negedge clk); irq_in = 8'h04;
        wr(A_SET, 32'h04);
        rd(A_VEC, 32'd2, "R9 vector lowest of two");
        wr(A_ACK, 32'h24);
        rd(A_STATUS, 32'h04, "R6 level relatch, R4 edge bit cleared");

        // R5 edge line 6 held high through acknowledge
        @(negedge clk); irq_in = 8'h44;
        @(negedge clk);
        rd(A_STATUS, 32'h44, "R5 edge held latched");
        wr(A_ACK, 32'h40);
        rd(A_STATUS, 32'h04, "R5 no relatch on steady high");
        @(negedge clk); irq_in = 8'h04;

        // R10 edge on line 7 in the same cycle as its acknowledge
        @(negedge clk);
        irq_in = 8'h84; addr = A_ACK; wr_data = 32'h80; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(A_STATUS, 32'h84, "R10 event beats acknowledge");
        wr(A_ACK, 32'h80);
        rd(A_STATUS, 32'h04, "R10 later acknowledge clears");

        @(negedge clk); irq_in = 8'h00;
        wr(A_ACK, 32'hFFFF_FFFF);
        rd(A_STATUS, 32'h0, "R4 acknowledge all");
        chk("R8 irq low with nothing pending", {31'b0, irq_out}, 32'h0);
        rd(A_VEC, 32'hFFFF_FFFF, "R9 vector idle");

        // R3 whole enable write
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, 32'h0000_00FF, "R3 enable upper bits zero");
        wr(A_EN, 32'h0);
        rd(A_EN, 32'h0, "R3 enable write zero");
        @(negedge clk); irq_in = 8'h02;
        @(negedge clk);
        rd(A_PEND, 32'h0, "R3 disabled line not pending");
        chk("R3 irq low when all disabled", {31'b0, irq_out}, 32'h0);

        // R1 ignored writes and write-only reads
        wr(A_STATUS, 32'hFF);
        rd(A_STATUS, 32'h02, "R1 status write ignored");
        wr(5'h09, 32'hFF);
        rd(A_EN, 32'h0, "R1 misaligned write ignored");
        wr(A_SET, 32'h10);
        rd(A_SET, 32'h0, "R1 set-enable reads zero");
        rd(A_ACK, 32'h0, "R1 acknowledge reads zero");
        rd(A_EN, 32'h10, "R1 aligned set after misaligned");

        repeat (3) @(negedge clk);
        chk("R1 all reads answered", exp_q.size(), 32'h0);
        summary();
        $finish;
    end

endmodule